// File: doc/BRIEF.md
# Chained Watchdog Counter Bank

This block is a bank of 64-bit down-counters reached through a small register port. Each counter has a control word and a count value split across two 32-bit words. A counter runs either once from its loaded value to zero, or waits for a trigger and reloads on each one. The trigger a counter can take is the end-of-count pulse of the counter just below it in the bank. A select register names the counter whose end of count raises the watchdog reset output.

The intended use pairs two neighbours. The upper counter is the watchdog and sits in trigger mode. The lower counter is a helper in one-shot mode, loaded with zero. Software refreshes the watchdog by clearing and then setting the helper's enable bit. The helper then ends at once, and its end pulse reloads the watchdog counter. The watchdog counter keeps its enable set the whole time, so a refresh never leaves it switched off. Reading the low count word also captures the high word, so a later read of the high word gives a 64-bit value taken at one instant.

Bus timing: a request is taken at the rising clock edge while `bus_valid_i` is high. Read data shows on `bus_rdata_o` after that same edge and holds until the next read.

Top module: `wdt_chain_bank`

## Requirements
- R1: After reset every control word reads 0x0000_0200 (prescaler 2, all other fields 0), every count word reads 0, the select register reads 0 and `wdt_rst_o` is low.
- R2: Counter n has its control word at byte address n*0x10, its low count word at n*0x10+0x4 and its high count word at n*0x10+0x8. The select register is at 0x40. Control bit 0 is enable, bit 1 is the read-only active flag, bits 3:2 are the mode (11 = trigger mode, any other code = one-shot), bits 7:4 are the trigger source and bits 15:8 are the prescaler. Bits 31:16 read 0.
- R3: A write to a low or high count word sets both that half of the reload value and that half of the current count.
- R4: An active counter decrements once every max(P,2) clocks, where P is its prescaler field. The first decrement comes max(P,2) clocks after the edge that started it.
- R5: In one-shot mode, a write that sets enable from 0 makes the counter active. When the count reaches 0, the counter emits one end-of-count pulse and clears active. If the count is already 0 when enable is set, the pulse comes right away and active stays 0.
- R6: In trigger mode, setting enable leaves the counter idle. With source code 0x5, each end-of-count pulse of counter n-1 reloads counter n from its reload value and makes it active, and the counter again pulses end-of-count and goes idle when it reaches 0. Counter 0 has no predecessor, and other source codes never trigger.
- R7: A write that clears enable clears active and freezes the count. No decrement happens on that edge.
- R8: A read of a low count word returns the low half and latches the high half. A read of the high word returns the latched half, not the live one.
- R9: The select register holds one bit per counter. A write with more than one bit set is ignored. `wdt_rst_o` is high for exactly the cycle after the edge where a selected counter produces its end-of-count pulse.
- R10: Clearing and then setting the enable of a zero-loaded one-shot helper restarts the neighbouring trigger-mode watchdog from its full reload value, so the earlier timeout never fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| bus_valid_i | input | 1 | Register request this cycle |
| bus_write_i | input | 1 | 1 = write, 0 = read |
| bus_addr_i | input | ADDR_W | Byte address |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, registered |
| wdt_rst_o | output | 1 | Watchdog reset pulse |

## Verification
The bench times expiry to the exact cycle for random loads, prescalers (including the illegal values 0 and 1) and one-shot mode codes. A prescaler that is off by one, or that does not clamp to 2, moves the pulse, and the bench catches that shift. It reads the high word while the count carries across the 32-bit boundary. A design that passes the live high word through would return 0 instead of the latched 1. The refresh sequence is repeated before the first timeout. A design that failed to reload, or that reloaded from the live count, would pulse the reset early. The bench also checks a zero-count enable, a rejected multi-bit select write and a trigger from an unmatched source code. Each of these shows up at the ports as a stray reset pulse or a changed count.

// File: rtl/wdt_bank_pkg.sv
package wdt_bank_pkg;

    localparam int unsigned WORD_W = 32;
    localparam int unsigned CNT_W  = 2 * WORD_W;
    localparam int unsigned PSC_W  = 8;
    localparam int unsigned SRC_W  = 4;
    localparam int unsigned CTRL_USED = PSC_W + SRC_W + 4;

    typedef enum logic [1:0] {
        MODE_ONESHOT = 2'b00,
        MODE_ALT1    = 2'b01,
        MODE_ALT2    = 2'b10,
        MODE_HWTRIG  = 2'b11
    } cnt_mode_e;

    localparam logic [SRC_W-1:0] SRC_PREV_END = 4'h5;
    localparam logic [PSC_W-1:0] PSC_MIN      = 8'd2;

    localparam logic [3:0] SUB_CTRL = 4'h0;
    localparam logic [3:0] SUB_LO   = 4'h4;
    localparam logic [3:0] SUB_HI   = 4'h8;

    typedef struct packed {
        logic              en;
        cnt_mode_e         mode;
        logic [SRC_W-1:0]  src;
        logic [PSC_W-1:0]  psc;
        logic              active;
        logic              end_ev;
        logic [CNT_W-1:0]  reload;
        logic [CNT_W-1:0]  count;
        logic [WORD_W-1:0] hold;
    } slice_state_t;

    localparam slice_state_t SLICE_RST = '{
        en: 1'b0, mode: MODE_ONESHOT, src: '0, psc: PSC_MIN,
        active: 1'b0, end_ev: 1'b0, reload: '0, count: '0, hold: '0
    };

    function automatic logic [WORD_W-1:0] pack_ctrl(input slice_state_t s);
        return {{(WORD_W-CTRL_USED){1'b0}}, s.psc, s.src, s.mode, s.active, s.en};
    endfunction

endpackage

// File: rtl/wdt_tick_gen.sv
module wdt_tick_gen #(
    parameter int unsigned DIV_W = 8
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             run_i,
    input  logic             clr_i,
    input  logic [DIV_W-1:0] div_i,
    output logic             tick_o
);
    localparam logic [DIV_W-1:0] DIV_FLOOR = DIV_W'(2);

    logic [DIV_W-1:0] div_eff;
    logic [DIV_W-1:0] ph_d, ph_q;

    always_comb begin
        div_eff = (div_i < DIV_FLOOR) ? DIV_FLOOR : div_i;
        tick_o  = run_i && !clr_i && (ph_q >= (div_eff - 1'b1));
        if (clr_i || !run_i) begin
            ph_d = '0;
        end else if (tick_o) begin
            ph_d = '0;
        end else begin
            ph_d = ph_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) ph_q <= '0;
        else         ph_q <= ph_d;
    end

    // R4
    idle_phase_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !run_i |=> (ph_q == '0));

endmodule

// File: rtl/wdt_count_slice.sv
module wdt_count_slice
    import wdt_bank_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              ctrl_we_i,
    input  logic              lo_we_i,
    input  logic              hi_we_i,
    input  logic              lo_re_i,
    input  logic [WORD_W-1:0] wdata_i,
    input  logic              trig_i,
    output logic [WORD_W-1:0] ctrl_rd_o,
    output logic [WORD_W-1:0] lo_rd_o,
    output logic [WORD_W-1:0] hi_rd_o,
    output logic              end_o
);
    slice_state_t s_d, s_q;
    logic         tick;
    logic         en_rise;
    logic         trig_hit;
    logic         psc_clr;
    cnt_mode_e    wr_mode;

    wdt_tick_gen #(.DIV_W(PSC_W)) u_tick (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .run_i  (s_q.active),
        .clr_i  (psc_clr),
        .div_i  (s_q.psc),
        .tick_o (tick)
    );

    always_comb begin
        s_d        = s_q;
        s_d.end_ev = 1'b0;
        wr_mode    = cnt_mode_e'(wdata_i[3:2]);
        en_rise    = ctrl_we_i && wdata_i[0] && !s_q.en;
        trig_hit   = s_q.en && (s_q.mode == MODE_HWTRIG) &&
                     (s_q.src == SRC_PREV_END) && trig_i;
        psc_clr    = en_rise || trig_hit;

        if (ctrl_we_i) begin
            s_d.en   = wdata_i[0];
            s_d.mode = wr_mode;
            s_d.src  = wdata_i[7:4];
            s_d.psc  = wdata_i[15:8];
            if (!wdata_i[0]) begin
                s_d.active = 1'b0;
            end else if (en_rise) begin
                if (wr_mode == MODE_HWTRIG) begin
                    s_d.active = 1'b0;
                end else if (s_q.count == '0) begin
                    s_d.end_ev = 1'b1;
                    s_d.active = 1'b0;
                end else begin
                    s_d.active = 1'b1;
                end
            end
        end else if (trig_hit) begin
            s_d.count  = s_q.reload;
            s_d.active = (s_q.reload != '0);
            s_d.end_ev = (s_q.reload == '0);
        end else if (s_q.active) begin
            if (s_q.count == '0) begin
                s_d.end_ev = 1'b1;
                s_d.active = 1'b0;
            end else if (tick) begin
                s_d.count = s_q.count - CNT_W'(1);
                if (s_q.count == CNT_W'(1)) begin
                    s_d.end_ev = 1'b1;
                    s_d.active = 1'b0;
                end
            end
        end

        if (lo_we_i) begin
            s_d.reload[WORD_W-1:0] = wdata_i;
            s_d.count[WORD_W-1:0]  = wdata_i;
        end
        if (hi_we_i) begin
            s_d.reload[CNT_W-1:WORD_W] = wdata_i;
            s_d.count[CNT_W-1:WORD_W]  = wdata_i;
        end
        if (lo_re_i) begin
            s_d.hold = s_q.count[CNT_W-1:WORD_W];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) s_q <= SLICE_RST;
        else         s_q <= s_d;
    end

    assign ctrl_rd_o = pack_ctrl(s_q);
    assign lo_rd_o   = s_q.count[WORD_W-1:0];
    assign hi_rd_o   = s_q.hold;
    assign end_o     = s_q.end_ev;

    // R7
    active_needs_en_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.active |-> s_q.en);

    // R7
    frozen_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!s_q.en && !lo_we_i && !hi_we_i) |=> $stable(s_q.count));

    // R4
    single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (s_q.active && !lo_we_i && !hi_we_i && !trig_hit) |=>
        ((s_q.count == $past(s_q.count)) || (s_q.count == $past(s_q.count) - CNT_W'(1))));

    // R5
    end_clears_active_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        s_q.end_ev |-> !s_q.active);

endmodule

// File: rtl/wdt_chain_bank.sv
module wdt_chain_bank
    import wdt_bank_pkg::*;
#(
    parameter int unsigned NUM_CNT = 4,
    parameter int unsigned ADDR_W  = 8
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bus_valid_i,
    input  logic              bus_write_i,
    input  logic [ADDR_W-1:0] bus_addr_i,
    input  logic [31:0]       bus_wdata_i,
    output logic [31:0]       bus_rdata_o,
    output logic              wdt_rst_o
);
    localparam int unsigned       IDX_W    = ADDR_W - 4;
    localparam logic [ADDR_W-1:0] SEL_ADDR = ADDR_W'(NUM_CNT * 16);

    typedef struct packed {
        logic [NUM_CNT-1:0] sel;
        logic [WORD_W-1:0]  rdata;
    } top_state_t;

    top_state_t t_d, t_q;

    logic              wr_en, rd_en, sel_hit;
    logic [IDX_W-1:0]  idx;
    logic [3:0]        sub;
    logic [NUM_CNT-1:0] sel_wr;
    logic [NUM_CNT-1:0] ctrl_we, lo_we, hi_we, lo_re, trig_w, end_w;
    logic [WORD_W-1:0]  ctrl_rd [NUM_CNT];
    logic [WORD_W-1:0]  lo_rd   [NUM_CNT];
    logic [WORD_W-1:0]  hi_rd   [NUM_CNT];

    assign wr_en   = bus_valid_i && bus_write_i;
    assign rd_en   = bus_valid_i && !bus_write_i;
    assign idx     = bus_addr_i[ADDR_W-1:4];
    assign sub     = bus_addr_i[3:0];
    assign sel_hit = (bus_addr_i == SEL_ADDR);
    assign sel_wr  = bus_wdata_i[NUM_CNT-1:0];

    for (genvar gi = 0; gi < NUM_CNT; gi++) begin : g_cnt
        assign ctrl_we[gi] = wr_en && (idx == IDX_W'(gi)) && (sub == SUB_CTRL);
        assign lo_we[gi]   = wr_en && (idx == IDX_W'(gi)) && (sub == SUB_LO);
        assign hi_we[gi]   = wr_en && (idx == IDX_W'(gi)) && (sub == SUB_HI);
        assign lo_re[gi]   = rd_en && (idx == IDX_W'(gi)) && (sub == SUB_LO);

        if (gi == 0) begin : g_head
            assign trig_w[gi] = 1'b0;
        end else begin : g_link
            assign trig_w[gi] = end_w[gi-1];
        end

        wdt_count_slice u_slice (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .ctrl_we_i (ctrl_we[gi]),
            .lo_we_i   (lo_we[gi]),
            .hi_we_i   (hi_we[gi]),
            .lo_re_i   (lo_re[gi]),
            .wdata_i   (bus_wdata_i),
            .trig_i    (trig_w[gi]),
            .ctrl_rd_o (ctrl_rd[gi]),
            .lo_rd_o   (lo_rd[gi]),
            .hi_rd_o   (hi_rd[gi]),
            .end_o     (end_w[gi])
        );
    end

    always_comb begin
        t_d = t_q;
        if (wr_en && sel_hit && ((sel_wr & (sel_wr - 1'b1)) == '0)) begin
            t_d.sel = sel_wr;
        end
        if (rd_en) begin
            t_d.rdata = '0;
            if (sel_hit) begin
                t_d.rdata = {{(WORD_W-NUM_CNT){1'b0}}, t_q.sel};
            end
            for (int i = 0; i < NUM_CNT; i++) begin
                if (idx == IDX_W'(i)) begin
                    case (sub)
                        SUB_CTRL: t_d.rdata = ctrl_rd[i];
                        SUB_LO:   t_d.rdata = lo_rd[i];
                        SUB_HI:   t_d.rdata = hi_rd[i];
                        default:  t_d.rdata = '0;
                    endcase
                end
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) t_q <= '0;
        else         t_q <= t_d;
    end

    assign bus_rdata_o = t_q.rdata;
    assign wdt_rst_o   = |(end_w & t_q.sel);

    // R9
    sel_reject_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (wr_en && sel_hit && ($countones(sel_wr) > 1)) |=> $stable(t_q.sel));

    // R9
    sel_onehot_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0(t_q.sel));

endmodule

// File: tb/wdt_chain_bank_tb_top.sv
module wdt_chain_bank_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 8;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              bus_valid = 1'b0;
    logic              bus_write = 1'b0;
    logic [ADDR_W-1:0] bus_addr = '0;
    logic [31:0]       bus_wdata = '0;
    logic [31:0]       bus_rdata;
    logic              wdt_rst;

    int n_chk = 0;
    int n_fail = 0;
    int pulses = 0;

    wdt_chain_bank #(.NUM_CNT(4), .ADDR_W(ADDR_W)) dut_i (
        .clk_i       (clk),
        .rst_ni      (rst_n),
        .bus_valid_i (bus_valid),
        .bus_write_i (bus_write),
        .bus_addr_i  (bus_addr),
        .bus_wdata_i (bus_wdata),
        .bus_rdata_o (bus_rdata),
        .wdt_rst_o   (wdt_rst)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(negedge clk) if (rst_n && wdt_rst) pulses++;

    function automatic logic [7:0] a_ctrl(int n); return 8'(n * 16);     endfunction
    function automatic logic [7:0] a_lo(int n);   return 8'(n * 16 + 4); endfunction
    function automatic logic [7:0] a_hi(int n);   return 8'(n * 16 + 8); endfunction
    localparam logic [7:0] A_SEL = 8'h40;

    function automatic logic [31:0] ctrl_word(bit en, int mode, int src, int psc);
        return {16'h0, 8'(psc), 4'(src), 2'(mode), 1'b0, en};
    endfunction

    function automatic int expiry_delay(int load, int psc);
        return load * ((psc < 2) ? 2 : psc);
    endfunction

    task automatic chk(string req, logic [63:0] got, logic [63:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %0h expected %0h", req, got, exp);
        end
    endtask

    task automatic wr(logic [7:0] a, logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_valid = 1'b0; bus_write = 1'b0;
    endtask

    task automatic rd(logic [7:0] a, output logic [31:0] d);
        bus_valid = 1'b1; bus_write = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_valid = 1'b0;
        d = bus_rdata;
    endtask

    task automatic idle(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        int p0, d;
        void'($urandom(32'd4242));
        idle(3);
        rst_n = 1'b1;

        // R1 reset values, R2 layout
        chk("R1 rst_o", {63'h0, wdt_rst}, 64'h0);
        rd(a_ctrl(0), v); chk("R1 ctrl0", v, 32'h200);
        rd(a_ctrl(3), v); chk("R2 ctrl3", v, 32'h200);
        rd(a_lo(1), v);   chk("R1 lo1", v, 0);
        rd(a_hi(2), v);   chk("R1 hi2", v, 0);
        rd(A_SEL, v);     chk("R1 sel", v, 0);

        // R3 count write, R8 plain capture
        wr(a_lo(2), 32'hDEADBEEF);
        wr(a_hi(2), 32'h12345678);
        rd(a_lo(2), v); chk("R3 lo2", v, 32'hDEADBEEF);
        rd(a_hi(2), v); chk("R8 hi2", v, 32'h12345678);

        // R8 coherent read across the word boundary
        wr(a_lo(3), 32'h3);
        wr(a_hi(3), 32'h1);
        wr(a_ctrl(3), ctrl_word(1, 0, 0, 2));
        rd(a_lo(3), v); chk("R8 lo3 first", v, 32'h3);
        idle(10);
        rd(a_hi(3), v); chk("R8 hi3 latched", v, 32'h1);
        rd(a_lo(3), v); chk("R4 lo3 after 12", v, 32'hFFFFFFFD);
        rd(a_hi(3), v); chk("R8 hi3 relatched", v, 32'h0);
        wr(a_ctrl(3), ctrl_word(0, 0, 0, 2));

        // R7 freeze on disable
        wr(a_lo(2), 32'd100);
        wr(a_hi(2), 32'd0);
        wr(a_ctrl(2), ctrl_word(1, 0, 0, 2));
        idle(10);
        wr(a_ctrl(2), ctrl_word(0, 0, 0, 2));
        rd(a_lo(2), v); chk("R7 frozen lo2", v, 32'd95);
        idle(5);
        rd(a_lo(2), v); chk("R7 still frozen", v, 32'd95);
        rd(a_ctrl(2), v); chk("R7 ctrl2 inactive", v, 32'h200);

        // R5 immediate end on zero count, R9 pulse width
        wr(A_SEL, 32'h1);
        p0 = pulses;
        wr(a_ctrl(0), ctrl_word(1, 0, 0, 2));
        chk("R5 immediate rst", {63'h0, wdt_rst}, 64'h1);
        idle(1);
        chk("R9 one cycle pulse", {63'h0, wdt_rst}, 64'h0);
        chk("R9 pulse count", pulses - p0, 1);
        rd(a_ctrl(0), v); chk("R5 ctrl0 inactive", v, 32'h201);

        // R9 multi-bit select rejected
        wr(A_SEL, 32'h3);
        rd(A_SEL, v); chk("R9 sel reject", v, 32'h1);
        wr(A_SEL, 32'h2);
        rd(A_SEL, v); chk("R9 sel accept", v, 32'h2);

        // R6 / R10 chained refresh
        wr(a_lo(1), 32'd20);
        wr(a_hi(1), 32'd0);
        wr(a_ctrl(1), ctrl_word(1, 3, 5, 2));
        rd(a_ctrl(1), v); chk("R6 trig idle ctrl1", v, 32'h25D);
        wr(a_lo(2), 32'd7);
        wr(a_hi(2), 32'd0);
        wr(a_ctrl(2), ctrl_word(1, 3, 4, 2));
        idle(20);
        rd(a_lo(1), v); chk("R6 no count while idle", v, 32'd20);
        p0 = pulses;
        wr(a_ctrl(0), ctrl_word(0, 0, 0, 2));
        wr(a_ctrl(0), ctrl_word(1, 0, 0, 2));
        idle(9);
        rd(a_lo(1), v); chk("R6 reloaded and counting", v, 32'd16);
        idle(19);
        wr(a_ctrl(0), ctrl_word(0, 0, 0, 2));
        wr(a_ctrl(0), ctrl_word(1, 0, 0, 2));
        d = 1 + expiry_delay(20, 2);
        idle(d - 1);
        chk("R10 no early rst", {63'h0, wdt_rst}, 64'h0);
        chk("R10 no pulse from old timeout", pulses - p0, 0);
        idle(1);
        chk("R6 rst at expiry", {63'h0, wdt_rst}, 64'h1);
        rd(a_ctrl(1), v); chk("R6 idle after end", v, 32'h25D);
        rd(a_lo(2), v);   chk("R6 src4 ignored lo2", v, 32'd7);
        rd(a_ctrl(2), v); chk("R6 src4 ignored ctrl2", v, 32'h24D);
        wr(a_ctrl(1), ctrl_word(0, 0, 0, 2));
        wr(a_ctrl(2), ctrl_word(0, 0, 0, 2));

        // R4 / R5 random one-shot expiry timing
        for (int it = 0; it < 16; it++) begin
            int ld, ps, md;
            ld = 1 + int'($urandom % 30);
            ps = int'($urandom % 6);
            md = int'($urandom % 3);
            wr(a_lo(1), 32'(ld));
            wr(a_hi(1), 32'd0);
            wr(a_ctrl(1), ctrl_word(1, md, 0, ps));
            d = expiry_delay(ld, ps);
            idle(d - 1);
            chk($sformatf("R4 no rst before %0d", d), {63'h0, wdt_rst}, 64'h0);
            idle(1);
            chk($sformatf("R5 rst at %0d", d), {63'h0, wdt_rst}, 64'h1);
            rd(a_ctrl(1), v); chk("R5 active cleared", v, ctrl_word(1, md, 0, ps));
            wr(a_ctrl(1), ctrl_word(0, md, 0, ps));
        end

        // R9 unselected expiry gives no pulse
        wr(A_SEL, 32'h0);
        p0 = pulses;
        wr(a_lo(1), 32'd3);
        wr(a_ctrl(1), ctrl_word(1, 0, 0, 2));
        idle(10);
        chk("R9 no pulse when unselected", pulses - p0, 0);

        finish_run();
    end
endmodule